// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. A four-wire interface connects it to the tester: test clock, mode select, serial data in and serial data out. An optional active-low test reset input is also provided. A sixteen-state controller, stepped on each rising test clock, follows the mode-select line through the instruction-scan and data-scan sequences. During an instruction scan, a shift stage is loaded serially. Its contents become the current instruction only when the scan reaches its update step.

The current instruction picks which data register sits between serial in and serial out. Two choices exist. The first is a one-cell bypass register. The second is an external data-register hook, which gives capture, shift and update strobes, a select line and a serial return. Boundary cells and device-specific registers attach to this hook. Serial out changes on the falling test clock and is enabled only while a shift state is active.

Top module: `scan_port_top`

## Requirements
- R1: The controller has sixteen states, reported on `tap_state` with these codes: 0 Reset, 1 Idle, 2 Select-DR, 3 Capture-DR, 4 Shift-DR, 5 Exit1-DR, 6 Pause-DR, 7 Exit2-DR, 8 Update-DR, 9 Select-IR, 10 Capture-IR, 11 Shift-IR, 12 Exit1-IR, 13 Pause-IR, 14 Exit2-IR, 15 Update-IR. On each rising `tck` it moves along the standard transition graph selected by `tms`. Idle and the Pause states hold while `tms` is 0. Exit2 returns to Shift when `tms` is 0 and goes to Update when `tms` is 1.
- R2: Five consecutive rising edges with `tms` high bring the controller to Reset from any state. It then stays in Reset while `tms` stays high.
- R3: When `trst_n` goes low, the controller moves to Reset and the instruction becomes all-ones at once, without waiting for a clock edge.
- R4: In Capture-IR the instruction shift stage loads 0b0001. In Shift-IR it shifts one cell per rising edge, taking `tdi` into bit 3 and presenting bit 0 toward `tdo`. It does not move in the Pause or Exit states.
- R5: The current instruction on `instr` changes only when leaving Update-IR, where it takes the shifted value, or while in Reset, where it becomes 0b1111. It keeps its value through Shift, Pause and Exit, and throughout Update-IR itself.
- R6: Every instruction other than the external code, including 0b1111, selects the one-cell bypass register. Bypass loads 0 in Capture-DR, and each Shift-DR edge copies `tdi` into it.
- R7: The external code 0b0010 raises `ext_sel`. While it is selected, `ext_capture`, `ext_shift` and `ext_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and `tdo` carries `ext_tdo` in Shift-DR. With any other instruction the three strobes stay low.
- R8: `tdo` and `tdo_oe` update on the falling edge of `tck`. `tdo_oe` is 1 only while the state is Shift-DR or Shift-IR. At all other times `tdo` is 0 and `tdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |
| ext_tdo | input | 1 | Serial return from the external data register |
| ext_sel | output | 1 | External data register selected by the instruction |
| ext_capture | output | 1 | External register capture strobe |
| ext_shift | output | 1 | External register shift strobe |
| ext_update | output | 1 | External register update strobe |
| tap_state | output | 4 | Current controller state code |
| instr | output | 4 | Current latched instruction |

## Verification
Several rules are checked by assertions on every rising edge:
- a run of five high `tms` samples always ends in Reset, and Reset holds while `tms` stays high;
- Idle persists while `tms` is low, and Exit2 resumes shifting when `tms` is low;
- the instruction latch stays still outside Update-IR and Reset;
- the capture pattern and the bypass capture value are loaded as required;
- the three external strobes are never active together;
- serial out is silent outside the Shift states.

Other behaviour can be seen only through bench scenarios. A long pseudo-random walk covers all 32 state and `tms` pairs against an independent transition model. Directed scans show the least-significant-first order of instruction bits and the one-cycle delay through bypass. They also cover routing of the external return, a paused instruction scan that ends with the correct value, and the asynchronous effect of test reset in the middle of a scan.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

    typedef enum logic [3:0] {
        ST_RESET  = 4'd0,
        ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,
        ST_CAP_DR = 4'd3,
        ST_SH_DR  = 4'd4,
        ST_EX1_DR = 4'd5,
        ST_PAU_DR = 4'd6,
        ST_EX2_DR = 4'd7,
        ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,
        ST_CAP_IR = 4'd10,
        ST_SH_IR  = 4'd11,
        ST_EX1_IR = 4'd12,
        ST_PAU_IR = 4'd13,
        ST_EX2_IR = 4'd14,
        ST_UPD_IR = 4'd15
    } tap_state_e;

    // Strobes for the external data-register hook
    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
    } dr_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

    function automatic logic is_shift(input tap_state_e s);
        return (s == ST_SH_DR) || (s == ST_SH_IR);
    endfunction

endpackage

// File: rtl/scan_port_fsm.sv
module scan_port_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= tap_next(state, tms);
    end

    // Run length of consecutive high tms samples, saturating at five
    logic [2:0] ones_run;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)               ones_run <= 3'd0;
        else if (!tms)             ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    p_five_high_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> (state == ST_RESET));
    p_hold_reset_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));
    p_idle_stay_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IDLE && !tms) |=> (state == ST_IDLE));
    p_exit2_resume_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_EX2_IR && !tms) |=> (state == ST_SH_IR));

endmodule

// File: rtl/scan_port_ir.sv
module scan_port_ir
    import scan_port_pkg::*;
#(
    parameter int IR_W = 4,
    parameter logic [IR_W-1:0] CAP_PAT = IR_W'(1)
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_cur,
    output logic            ir_lsb
);

    localparam logic [IR_W-1:0] BYP_CODE = {IR_W{1'b1}};

    logic [IR_W-1:0] ir_sh;

    // Shift stage: capture pattern, then LSB-first shift toward tdo
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh <= CAP_PAT;
        end else begin
            case (state)
                ST_CAP_IR: ir_sh <= CAP_PAT;
                ST_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                default:   ir_sh <= ir_sh;
            endcase
        end
    end

    // Parallel latch: loads on leaving Update-IR, forced to bypass in Reset
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                 ir_cur <= BYP_CODE;
        else if (state == ST_RESET)  ir_cur <= BYP_CODE;
        else if (state == ST_UPD_IR) ir_cur <= ir_sh;
    end

    assign ir_lsb = ir_sh[0];

    p_capture_pattern_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sh == CAP_PAT));
    p_pause_frozen_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_PAU_IR) |=> $stable(ir_sh));
    p_latch_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_cur));
    p_reset_bypass_r5: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir_cur == BYP_CODE));

endmodule

// File: rtl/scan_port_dr.sv
module scan_port_dr
    import scan_port_pkg::*;
#(
    parameter int IR_W = 4,
    parameter logic [IR_W-1:0] EXT_CODE = IR_W'(2)
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    input  logic [IR_W-1:0] ir_cur,
    input  logic            ir_lsb,
    input  logic            ext_tdo,
    output logic            ext_sel,
    output dr_ctl_t         ext_ctl,
    output logic            tdo,
    output logic            tdo_oe
);

    logic byp;
    logic dr_lsb;
    logic tdo_d;

    assign ext_sel = (ir_cur == EXT_CODE);

    always_comb begin
        ext_ctl         = '0;
        ext_ctl.capture = ext_sel && (state == ST_CAP_DR);
        ext_ctl.shift   = ext_sel && (state == ST_SH_DR);
        ext_ctl.update  = ext_sel && (state == ST_UPD_DR);
    end

    // One-cell bypass register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)                            byp <= 1'b0;
        else if (!ext_sel && state == ST_CAP_DR) byp <= 1'b0;
        else if (!ext_sel && state == ST_SH_DR)  byp <= tdi;
    end

    assign dr_lsb = ext_sel ? ext_tdo : byp;

    always_comb begin
        case (state)
            ST_SH_DR: tdo_d = dr_lsb;
            ST_SH_IR: tdo_d = ir_lsb;
            default:  tdo_d = 1'b0;
        endcase
    end

    // Output stage on the falling test clock
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= tdo_d;
            tdo_oe <= is_shift(state);
        end
    end

    p_bypass_capture_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && !ext_sel) |=> (byp == 1'b0));
    p_strobe_exclusive_r7: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({ext_ctl.capture, ext_ctl.shift, ext_ctl.update}));
    p_tdo_gate_r8: assert property (@(posedge tck) disable iff (!trst_n)
        !is_shift(state) |-> (!tdo_oe && !tdo));
    p_tdo_enable_r8: assert property (@(posedge tck) disable iff (!trst_n)
        is_shift(state) |-> tdo_oe);

endmodule

// File: rtl/scan_port_top.sv
module scan_port_top
    import scan_port_pkg::*;
#(
    parameter int IR_W = 4,
    parameter logic [IR_W-1:0] CAP_PAT  = IR_W'(1),
    parameter logic [IR_W-1:0] EXT_CODE = IR_W'(2)
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            tdo_oe,
    input  logic            ext_tdo,
    output logic            ext_sel,
    output logic            ext_capture,
    output logic            ext_shift,
    output logic            ext_update,
    output logic [3:0]      tap_state,
    output logic [IR_W-1:0] instr
);

    tap_state_e      st;
    logic [IR_W-1:0] ir_cur;
    logic            ir_lsb;
    dr_ctl_t         ctl;

    scan_port_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (st)
    );

    scan_port_ir #(.IR_W(IR_W), .CAP_PAT(CAP_PAT)) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (st),
        .ir_cur (ir_cur),
        .ir_lsb (ir_lsb)
    );

    scan_port_dr #(.IR_W(IR_W), .EXT_CODE(EXT_CODE)) u_dr (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state   (st),
        .ir_cur  (ir_cur),
        .ir_lsb  (ir_lsb),
        .ext_tdo (ext_tdo),
        .ext_sel (ext_sel),
        .ext_ctl (ctl),
        .tdo     (tdo),
        .tdo_oe  (tdo_oe)
    );

    assign ext_capture = ctl.capture;
    assign ext_shift   = ctl.shift;
    assign ext_update  = ctl.update;
    assign tap_state   = st;
    assign instr       = ir_cur;

endmodule

// File: tb/scan_port_top_bench.sv
module scan_port_top_bench;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       ext_tdo = 1'b0;
    logic       tdo, tdo_oe, ext_sel, ext_capture, ext_shift, ext_update;
    logic [3:0] tap_state;
    logic [3:0] instr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 tck = ~tck;

    scan_port_top u_scan_port_top (
        .tck         (tck),
        .trst_n      (trst_n),
        .tms         (tms),
        .tdi         (tdi),
        .tdo         (tdo),
        .tdo_oe      (tdo_oe),
        .ext_tdo     (ext_tdo),
        .ext_sel     (ext_sel),
        .ext_capture (ext_capture),
        .ext_shift   (ext_shift),
        .ext_update  (ext_update),
        .tap_state   (tap_state),
        .instr       (instr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Independent transition model from the R1 code list
    function automatic int model_next(input int s, input logic t);
        case (s)
            0:  return t ? 0  : 1;
            1:  return t ? 2  : 1;
            2:  return t ? 9  : 3;
            3:  return t ? 5  : 4;
            4:  return t ? 5  : 4;
            5:  return t ? 8  : 6;
            6:  return t ? 7  : 6;
            7:  return t ? 8  : 4;
            8:  return t ? 2  : 1;
            9:  return t ? 0  : 10;
            10: return t ? 12 : 11;
            11: return t ? 12 : 11;
            12: return t ? 15 : 13;
            13: return t ? 14 : 13;
            14: return t ? 15 : 11;
            default: return t ? 2 : 1;
        endcase
    endfunction

    // Called at falling edge + 1; returns at the next falling edge + 1
    task automatic tick(input logic t, input logic d, input logic e);
        tms = t;
        tdi = d;
        ext_tdo = e;
        @(posedge tck);
        #1;
        @(negedge tck);
        #1;
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
    endtask

    // Full instruction scan from Idle, checking the captured bits on tdo
    task automatic load_ir(input logic [3:0] v);
        logic [3:0] old;
        old = instr;
        tick(1, 0, 0);
        tick(1, 0, 0);
        tick(0, 0, 0);
        tick(0, 0, 0);
        chk("R8 shift-ir oe", int'(tdo_oe), 1);
        for (int i = 0; i < 4; i++) begin
            chk("R4 capture bit", int'(tdo), (i == 0) ? 1 : 0);
            tick(i == 3, v[i], 0);
        end
        chk("R4 exit1-ir state", int'(tap_state), 12);
        tick(1, 0, 0);
        chk("R5 instr held in update-ir", int'(instr), int'(old));
        tick(0, 0, 0);
        chk("R5 instr updated", int'(instr), int'(v));
        chk("R1 back to idle", int'(tap_state), 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [31:0] cov;
        int cur;
        logic t;
        logic [7:0] pat;
        logic [5:0] epat;

        // Reset state
        #11;
        chk("R3 reset state", int'(tap_state), 0);
        chk("R3 reset instr", int'(instr), 15);
        chk("R8 reset oe", int'(tdo_oe), 0);
        @(negedge tck);
        #1;
        trst_n = 1'b1;

        // R1: pseudo-random walk against the model
        lfsr = 16'hACE1;
        cov = '0;
        cur = 0;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            t = lfsr[0];
            cov[cur * 2 + int'(t)] = 1'b1;
            cur = model_next(cur, t);
            tick(t, lfsr[5], lfsr[9]);
            chk("R1 transition", int'(tap_state), cur);
            chk("R8 oe vs state", int'(tdo_oe), (cur == 4 || cur == 11) ? 1 : 0);
            if (cur != 4 && cur != 11) chk("R8 tdo quiet", int'(tdo), 0);
            if (n % 250 == 249) begin
                for (int k = 0; k < 5; k++) tick(1, 0, 0);
                chk("R2 five ones", int'(tap_state), 0);
                cur = 0;
            end
        end
        chk("R1 all 32 transitions seen", int'(cov == 32'hFFFF_FFFF), 1);

        // R2: exactly five ones from Shift-DR, then hold
        to_idle();
        tick(1, 0, 0);
        tick(0, 0, 0);
        tick(0, 0, 0);
        chk("R1 in shift-dr", int'(tap_state), 4);
        for (int k = 0; k < 4; k++) tick(1, 0, 0);
        chk("R2 four ones not reset", int'(tap_state), 9);
        tick(1, 0, 0);
        chk("R2 fifth one resets", int'(tap_state), 0);
        tick(1, 0, 0);
        chk("R2 reset holds", int'(tap_state), 0);
        chk("R5 reset instr", int'(instr), 15);

        // Instruction loads
        to_idle();
        load_ir(4'b1010);
        load_ir(4'b0101);
        chk("R6 unassigned code not ext", int'(ext_sel), 0);

        // Paused instruction scan resumes without update
        tick(1, 0, 0);
        tick(1, 0, 0);
        tick(0, 0, 0);
        tick(0, 0, 0);
        tick(0, 0, 0);
        tick(1, 1, 0);
        chk("R1 exit1-ir", int'(tap_state), 12);
        tick(0, 1, 0);
        tick(0, 1, 0);
        tick(0, 1, 0);
        chk("R1 pause-ir holds", int'(tap_state), 13);
        chk("R5 instr held in pause", int'(instr), 5);
        tick(1, 1, 0);
        tick(0, 1, 0);
        chk("R1 exit2 resumes shift", int'(tap_state), 11);
        chk("R4 pause kept bit order", int'(tdo), 0);
        tick(0, 1, 0);
        tick(1, 0, 0);
        tick(1, 0, 0);
        tick(0, 0, 0);
        chk("R4 paused scan value", int'(instr), 6);
        chk("R5 paused scan value latched", int'(ext_sel), 0);

        // Bypass data scan
        load_ir(4'b1111);
        pat = 8'hB5;
        tick(1, 0, 0);
        tick(0, 0, 0);
        chk("R7 no capture strobe in bypass", int'(ext_capture), 0);
        tick(0, 1, 0);
        chk("R6 bypass captured zero", int'(tdo), 0);
        chk("R7 no shift strobe in bypass", int'(ext_shift), 0);
        for (int i = 0; i < 8; i++) begin
            tick(i == 7, pat[i], 1);
            if (i < 7) chk("R6 bypass one-cell delay", int'(tdo), int'(pat[i]));
        end
        chk("R8 exit1-dr tdo off", int'(tdo_oe), 0);
        tick(1, 0, 0);
        chk("R7 no update strobe in bypass", int'(ext_update), 0);
        tick(0, 0, 0);

        // External hook
        load_ir(4'b0010);
        chk("R7 ext selected", int'(ext_sel), 1);
        epat = 6'b101101;
        tick(1, 0, 0);
        tick(0, 0, 0);
        chk("R7 capture strobe", int'(ext_capture), 1);
        chk("R7 no shift in capture", int'(ext_shift), 0);
        tick(0, 0, 0);
        chk("R7 shift strobe", int'(ext_shift), 1);
        chk("R7 no capture in shift", int'(ext_capture), 0);
        for (int i = 0; i < 6; i++) begin
            tick(i == 5, 0, epat[i]);
            if (i < 5) chk("R7 ext return on tdo", int'(tdo), int'(epat[i]));
        end
        chk("R7 shift strobe off in exit1", int'(ext_shift), 0);
        tick(1, 0, 0);
        chk("R7 update strobe", int'(ext_update), 1);
        tick(0, 0, 0);
        chk("R7 update strobe off", int'(ext_update), 0);

        // Asynchronous test reset mid-scan
        tick(1, 0, 0);
        tick(1, 0, 0);
        tick(0, 0, 0);
        tick(0, 0, 0);
        chk("R1 in shift-ir", int'(tap_state), 11);
        trst_n = 1'b0;
        #1;
        chk("R3 async state", int'(tap_state), 0);
        chk("R3 async instr", int'(instr), 15);
        chk("R3 async oe", int'(tdo_oe), 0);
        @(negedge tck);
        #1;
        trst_n = 1'b1;
        tick(0, 0, 0);
        chk("R3 leaves reset", int'(tap_state), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule